// File: doc/BRIEF.md
# Rotate and Field-Mask Merge Unit

This unit forms the extended logical datapath result. It rotates the left operand upward by a 5-bit amount and combines the rotated value with the right operand through a 4-bit truth-table function. It then merges this with an unmodified operand under a circular bit window. Inside the window, given by an inclusive first and last bit position, each result bit is the function output. Outside the window, each result bit is copied from the original left or right operand, as a select input chooses.

The decode that decides whether the extended path applies is done elsewhere. This block only receives the already-split fields. A parameter chooses between a registered result with one cycle of latency and a purely combinational result.

Top module: `rfm_merge_unit`

## Requirements
- R1: The left operand is rotated toward the most significant bit by `rot_amt_i` positions (0 to 31). Bits that leave bit 31 re-enter at bit 0.
- R2: Inside the window, result bit i is `func_i[{L[i], right_i[i]}]`, where L is the rotated left operand. So 4'b1000 is AND, 4'b1110 is OR, 4'b0110 is XOR, 4'b1100 passes L and 4'b1010 passes the right operand.
- R3: When `win_first_i <= win_last_i`, the window covers bits `win_first_i` through `win_last_i`, both ends included.
- R4: When `win_first_i > win_last_i`, the window wraps around. It covers bits `win_first_i` to 31 and bits 0 to `win_last_i`.
- R5: With `keep_right_i = 0`, every result bit outside the window equals the same bit of the unrotated `left_i`.
- R6: With `keep_right_i = 1`, every result bit outside the window equals the same bit of `right_i`.
- R7: With `REG_OUT = 1`, `result_o` shows the result for the inputs present at a rising clock edge, directly after that edge. With `REG_OUT = 0`, `result_o` follows the inputs with no clock.
- R8: With `REG_OUT = 1`, a high `rst` at a rising edge clears `result_o` to zero. The reset is synchronous and active high.
- R9: Equal first and last positions select exactly one bit. First 0 with last 31 selects the whole word, so nothing is kept from the select operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| left_i | input | 32 | Left operand, the one that is rotated |
| right_i | input | 32 | Right operand |
| rot_amt_i | input | 5 | Upward rotate amount |
| win_first_i | input | 5 | First bit position of the window |
| win_last_i | input | 5 | Last bit position of the window |
| func_i | input | 4 | Truth table of the two-input function |
| keep_right_i | input | 1 | 0: bits outside the window come from left_i; 1: from right_i |
| result_o | output | 32 | Merged result |

## Verification
The registered instance's result for the inputs driven at a falling edge is due right after the next rising edge, so it is sampled one time step past that edge. The combinational instance is sampled one time step after the falling edge that applied the inputs, before any clock edge. Every expected word is computed in the bench by rotating through a doubled word and building the window bit by bit. The sweeps cover all 1024 first/last pairs, all 32 rotate amounts with all 16 function codes, and both select values.

// File: rtl/rfm_pkg.sv
package rfm_pkg;

    localparam int RFM_W = 32;

    typedef enum logic [3:0] {
        LF_ZERO   = 4'b0000,
        LF_AND    = 4'b1000,
        LF_XOR    = 4'b0110,
        LF_OR     = 4'b1110,
        LF_PASS_L = 4'b1100,
        LF_PASS_R = 4'b1010,
        LF_ONES   = 4'b1111
    } lfunc_e;

    typedef struct packed {
        logic [3:0] func;
        logic       keep_right;
    } rfm_ctrl_t;

    // number of bits covered by a circular inclusive window
    function automatic int window_span(int first, int last, int width);
        if (first <= last)
            return last - first + 1;
        return width - first + last + 1;
    endfunction

endpackage

// File: rtl/rfm_rotator.sv
module rfm_rotator #(
    parameter int DATA_W = rfm_pkg::RFM_W,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [AMT_W-1:0]  amt_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] stage [AMT_W+1];

    assign stage[0] = data_i;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int SH = 1 << s;
        assign stage[s+1] = amt_i[s]
            ? {stage[s][DATA_W-1-SH:0], stage[s][DATA_W-1:DATA_W-SH]}
            : stage[s];
    end

    assign data_o = stage[AMT_W];

endmodule

// File: rtl/rfm_window.sv
module rfm_window #(
    parameter int DATA_W = rfm_pkg::RFM_W,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [AMT_W-1:0]  first_i,
    input  logic [AMT_W-1:0]  last_i,
    output logic [DATA_W-1:0] mask_o
);

    logic [DATA_W-1:0] at_or_above;
    logic [DATA_W-1:0] at_or_below;
    logic              wraps;

    for (genvar i = 0; i < DATA_W; i++) begin : g_pos
        localparam logic [AMT_W-1:0] POS = AMT_W'(i);
        assign at_or_above[i] = (POS >= first_i);
        assign at_or_below[i] = (POS <= last_i);
    end

    assign wraps  = (first_i > last_i);
    assign mask_o = wraps ? (at_or_above | at_or_below)
                          : (at_or_above & at_or_below);

endmodule

// File: rtl/rfm_truth.sv
module rfm_truth #(
    parameter int DATA_W = rfm_pkg::RFM_W
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [3:0]        func_i,
    output logic [DATA_W-1:0] y_o
);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign y_o[i] = func_i[{a_i[i], b_i[i]}];
    end

endmodule

// File: rtl/rfm_merge_unit.sv
module rfm_merge_unit #(
    parameter int DATA_W  = rfm_pkg::RFM_W,
    parameter bit REG_OUT = 1'b1,
    localparam int AMT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       left_i,
    input  logic [31:0]       right_i,
    input  logic [4:0]        rot_amt_i,
    input  logic [4:0]        win_first_i,
    input  logic [4:0]        win_last_i,
    input  logic [3:0]        func_i,
    input  logic              keep_right_i,
    output logic [31:0]       result_o
);

    import rfm_pkg::*;

    rfm_ctrl_t         ctrl;
    logic [DATA_W-1:0] rot_left;
    logic [DATA_W-1:0] fn_out;
    logic [DATA_W-1:0] win_mask;
    logic [DATA_W-1:0] keep_src;
    logic [DATA_W-1:0] merged;

    assign ctrl.func       = func_i;
    assign ctrl.keep_right = keep_right_i;

    rfm_rotator #(.DATA_W(DATA_W)) u_rot (
        .data_i (left_i),
        .amt_i  (rot_amt_i),
        .data_o (rot_left)
    );

    rfm_window #(.DATA_W(DATA_W)) u_win (
        .first_i (win_first_i),
        .last_i  (win_last_i),
        .mask_o  (win_mask)
    );

    rfm_truth #(.DATA_W(DATA_W)) u_fn (
        .a_i    (rot_left),
        .b_i    (right_i),
        .func_i (ctrl.func),
        .y_o    (fn_out)
    );

    assign keep_src = ctrl.keep_right ? right_i : left_i;
    assign merged   = (fn_out & win_mask) | (keep_src & ~win_mask);

    if (REG_OUT) begin : g_reg
        logic [DATA_W-1:0] result_q;
        always_ff @(posedge clk) begin
            if (rst) result_q <= '0;
            else     result_q <= merged;
        end
        assign result_o = result_q;

        AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (rst)
            !rst |=> (result_o == $past(merged)));  // R7
        AST_RESET_CLEAR: assert property (@(posedge clk)
            rst |=> (result_o == '0));  // R8
    end else begin : g_comb
        assign result_o = merged;
    end

    function automatic logic [DATA_W-1:0] ref_rotate(logic [DATA_W-1:0] x,
                                                     logic [AMT_W-1:0] n);
        logic [2*DATA_W-1:0] wide;
        wide = {x, x} << n;
        return wide[2*DATA_W-1:DATA_W];
    endfunction

    AST_ROTATE_WRAP: assert property (@(posedge clk) disable iff (rst)
        rot_left == ref_rotate(left_i, rot_amt_i));  // R1
    AST_WINDOW_ENDS: assert property (@(posedge clk) disable iff (rst)
        win_mask[win_first_i] && win_mask[win_last_i]);  // R3
    AST_WINDOW_SPAN: assert property (@(posedge clk) disable iff (rst)
        $countones(win_mask) == window_span(int'(win_first_i), int'(win_last_i), DATA_W));  // R4
    AST_OUTSIDE_KEPT: assert property (@(posedge clk) disable iff (rst)
        ((merged ^ (keep_right_i ? right_i : left_i)) & ~win_mask) == '0);  // R5

endmodule

// File: tb/rfm_merge_unit_tb_top.sv
module rfm_merge_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] left_i = '0, right_i = '0;
    logic [4:0]  rot_amt_i = '0, win_first_i = '0, win_last_i = '0;
    logic [3:0]  func_i = '0;
    logic        keep_right_i = 1'b0;
    logic [31:0] result_o, result_c;

    int checks = 0;
    int errors = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;  // 125 MHz

    rfm_merge_unit #(.REG_OUT(1'b1)) dut_i (
        .clk, .rst, .left_i, .right_i, .rot_amt_i, .win_first_i,
        .win_last_i, .func_i, .keep_right_i, .result_o(result_o)
    );

    rfm_merge_unit #(.REG_OUT(1'b0)) dut_comb_i (
        .clk, .rst, .left_i, .right_i, .rot_amt_i, .win_first_i,
        .win_last_i, .func_i, .keep_right_i, .result_o(result_c)
    );

    function automatic logic [31:0] next_rand(logic [31:0] x);
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    function automatic logic [31:0] expect_word(logic [31:0] l, logic [31:0] r,
            logic [4:0] amt, logic [4:0] f, logic [4:0] la, logic [3:0] fn, logic kr);
        logic [63:0] wide;
        logic [31:0] rl, res;
        bit inside_w;
        wide = {l, l} << amt;
        rl = wide[63:32];
        for (int i = 0; i < 32; i++) begin
            if (f <= la) inside_w = (i >= f) && (i <= la);
            else         inside_w = (i >= f) || (i <= la);
            if (inside_w) res[i] = fn[2 * int'(rl[i]) + int'(r[i])];
            else          res[i] = kr ? r[i] : l[i];
        end
        return res;
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(string req, logic [31:0] l, logic [31:0] r, logic [4:0] amt,
            logic [4:0] f, logic [4:0] la, logic [3:0] fn, logic kr);
        logic [31:0] exp;
        exp = expect_word(l, r, amt, f, la, fn, kr);
        @(negedge clk);
        left_i = l; right_i = r; rot_amt_i = amt;
        win_first_i = f; win_last_i = la; func_i = fn; keep_right_i = kr;
        #1;
        check({req, " comb"}, result_c, exp);   // R7 no clock needed
        @(posedge clk);
        #1;
        check({req, " reg"}, result_o, exp);    // R7 one edge later
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset", result_o, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R1: all rotate amounts, pass-left, full window
        for (int a = 0; a < 32; a++) begin
            seed = next_rand(seed);
            apply("R1", seed, ~seed, 5'(a), 5'd0, 5'd31, 4'b1100, 1'b0);
        end
        apply("R1", 32'h8000_0001, 32'h0, 5'd1, 5'd0, 5'd31, 4'b1100, 1'b0);

        // R2: every function code against every rotate amount
        for (int fn = 0; fn < 16; fn++) begin
            for (int a = 0; a < 32; a++) begin
                seed = next_rand(seed);
                apply("R2", seed, next_rand(seed ^ 32'h5a5a), 5'(a), 5'd0, 5'd31, 4'(fn), 1'(a));
            end
        end

        // R3/R4/R5/R6: every first/last pair, both keep sources
        for (int f = 0; f < 32; f++) begin
            for (int la = 0; la < 32; la++) begin
                seed = next_rand(seed);
                if (f <= la)
                    apply(((f + la) % 2 == 1) ? "R3 R6" : "R3 R5", seed, next_rand(seed),
                          5'(f + la), 5'(f), 5'(la), 4'b0110, 1'((f + la) % 2));
                else
                    apply(((f + la) % 2 == 1) ? "R4 R6" : "R4 R5", seed, next_rand(seed),
                          5'(f + la), 5'(f), 5'(la), 4'b1110, 1'((f + la) % 2));
            end
        end

        // R9: single-bit windows at both ends and full window
        apply("R9", 32'h0, 32'hFFFF_FFFF, 5'd0, 5'd0, 5'd0, 4'b1111, 1'b0);
        check("R9 single low", result_o, 32'h0000_0001);
        apply("R9", 32'h0, 32'hFFFF_FFFF, 5'd0, 5'd31, 5'd31, 4'b1111, 1'b0);
        check("R9 single high", result_o, 32'h8000_0000);
        apply("R9", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd7, 5'd0, 5'd31, 4'b0000, 1'b1);
        check("R9 full window", result_o, 32'h0);

        // R5/R6 fixed values: window bits 8..15, rotate by 4, AND
        apply("R5", 32'h1234_5678, 32'h0F0F_0F0F, 5'd4, 5'd8, 5'd15, 4'b1000, 1'b0);
        check("R5 fixed", result_o, 32'h1234_0778);
        apply("R6", 32'h1234_5678, 32'h0F0F_0F0F, 5'd4, 5'd8, 5'd15, 4'b1000, 1'b1);
        check("R6 fixed", result_o, 32'h0F0F_070F);

        // R8: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R8 mid reset", result_o, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule